// File: doc/BRIEF.md
# Dual-Port RAM with Same-Address Contention Arbiter

A clocked 1024 x 8 memory with two fully independent access ports, called left and right. Each port has its own active-low select, a read/not-write control, an active-low output enable, a 10-bit address and separate 8-bit write and read data. Read data is held in a register, and a drive flag marks the cycles when a pad would be driven. Both ports may read or write any location in the same cycle.

When both ports are selected on the same address, an arbiter grants one of them. It pulls the other port's active-low busy flag down in that same cycle. The held-off port's write is dropped, and its read result is marked invalid. The grant is held for as long as the clash lasts. The moment the winner leaves, busy returns high and the waiting port's access completes.

The winner depends on which event came second:
- If the addresses were already equal and steady when the selects overlapped, the port selected earlier wins.
- If both ports were already selected when their addresses came together, the port whose address was steady wins.
- A tie in the same cycle goes to a fixed port set by a parameter. By default that is the left port.

Top module: `dpr_contention_ram`

## Requirements
- R1: While reset is low and one cycle after it rises with idle inputs, both busy flags are 1 and both drive and valid outputs are 0.
- R2: Busy flags stay 1 whenever the two addresses differ or either select is high. Same-cycle writes from both ports to different addresses both land.
- R3: Sel-order mode applies when both addresses are unchanged from the previous cycle, both selects are now low and the addresses are equal. The port whose select was already low in the previous cycle wins, and the other port's busy flag goes to 0.
- R4: Address-order mode applies when both ports are selected, the addresses are now equal, and at least one address changed since the previous cycle. The port whose address did not change wins.
- R5: If neither port or both ports qualify as earlier in either mode, the port named by the tie parameter wins. The default is left.
- R6: The losing port's busy flag is 0 in the same cycle as the request. A write it presents at that clock edge leaves the memory unchanged.
- R7: The grant holds for every cycle the clash persists. In the first cycle without a clash, both busy flags are 1, and the waiting port's write is stored at that edge.
- R8: A read is select 0, read/not-write 1 and output enable 0 at an edge. In the next cycle it gives drive 1 and read data equal to the location's content before that edge's writes. Valid is 1 if busy was 1 at the request.
- R9: A read presented while its busy flag is 0 gives drive 1 and valid 0 in the next cycle.
- R10: Select high, or output enable high, at an edge gives drive 0 and valid 0 in the next cycle.
- R11: A write is select 0 and read/not-write 0 at an edge. With busy 1 it stores the write data at the address, and it gives drive 0 in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_sel_ni | input | 1 | Left port select, active low |
| l_rnw_i | input | 1 | Left read (1) / write (0) |
| l_oe_ni | input | 1 | Left output enable, active low |
| l_addr_i | input | 10 | Left address |
| l_wdata_i | input | 8 | Left write data |
| l_rdata_o | output | 8 | Left read data |
| l_drive_o | output | 1 | Left read data is being driven |
| l_valid_o | output | 1 | Left read data is trustworthy |
| l_busy_no | output | 1 | Left held off by arbitration, active low |
| r_sel_ni | input | 1 | Right port select, active low |
| r_rnw_i | input | 1 | Right read (1) / write (0) |
| r_oe_ni | input | 1 | Right output enable, active low |
| r_addr_i | input | 10 | Right address |
| r_wdata_i | input | 8 | Right write data |
| r_rdata_o | output | 8 | Right read data |
| r_drive_o | output | 1 | Right read data is being driven |
| r_valid_o | output | 1 | Right read data is trustworthy |
| r_busy_no | output | 1 | Right held off by arbitration, active low |

## Verification
The bench drives each arbitration mode with the left port winning and then with the right port winning. A design that mixed up the modes would grant the port whose event came later. It drives a same-cycle tie in both modes; a design without the tie rule would grant both ports or neither, and both ports would then write. It reads back the location after each blocked write. A leaky busy gate would show the loser's data there, and a design that never released the grant would lose the deferred write. Reads under busy must come back flagged invalid but still driven.

// File: rtl/dpr_pkg.sv
package dpr_pkg;
  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_L = 0;
  localparam int unsigned PORT_R = 1;

  typedef enum logic {
    ARB_BY_SEL  = 1'b0,
    ARB_BY_ADDR = 1'b1
  } arb_mode_e;
endpackage

// File: rtl/dpr_arbiter.sv
module dpr_arbiter
  import dpr_pkg::*;
#(
  parameter int unsigned AW       = 10,
  parameter bit          TIE_LEFT = 1'b1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [NUM_PORTS-1:0] sel_i,
  input  logic [AW-1:0]        addr_l_i,
  input  logic [AW-1:0]        addr_r_i,
  output logic [NUM_PORTS-1:0] busy_no
);
  logic [AW-1:0]        addr_l_q, addr_r_q;
  logic [NUM_PORTS-1:0] sel_q, early;
  logic                 conflict, conflict_q, win_l, win_l_q, past_ok;
  arb_mode_e            mode;

  assign conflict = sel_i[PORT_L] & sel_i[PORT_R] & (addr_l_i == addr_r_i);
  assign mode = ((addr_l_i == addr_l_q) && (addr_r_i == addr_r_q)) ? ARB_BY_SEL : ARB_BY_ADDR;

  always_comb begin
    if (mode == ARB_BY_SEL) early = sel_q;
    else                    early = {addr_r_i == addr_r_q, addr_l_i == addr_l_q};
    if (conflict_q)          win_l = win_l_q;
    else if (early == 2'b01) win_l = 1'b1;
    else if (early == 2'b10) win_l = 1'b0;
    else                     win_l = TIE_LEFT;
  end

  assign busy_no[PORT_L] = ~(conflict & ~win_l);
  assign busy_no[PORT_R] = ~(conflict & win_l);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_l_q   <= '0;
      addr_r_q   <= '0;
      sel_q      <= '0;
      conflict_q <= 1'b0;
      win_l_q    <= TIE_LEFT;
      past_ok    <= 1'b0;
    end else begin
      addr_l_q   <= addr_l_i;
      addr_r_q   <= addr_r_i;
      sel_q      <= sel_i;
      conflict_q <= conflict;
      win_l_q    <= win_l;
      past_ok    <= 1'b1;
    end
  end

  AST_ONE_LOSER: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_no != 2'b00); // R6
  AST_GRANT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && conflict && $past(conflict)) |-> (busy_no == $past(busy_no))); // R7
  AST_SEL_EARLY_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && conflict && $past(sel_i) == 2'b01 && $stable(addr_l_i) && $stable(addr_r_i))
      |-> (busy_no == 2'b01)); // R3
  AST_ADDR_EARLY_LEFT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && conflict && $past(sel_i) == 2'b11 && $past(addr_l_i != addr_r_i)
     && $stable(addr_l_i) && !$stable(addr_r_i)) |-> (busy_no == 2'b01)); // R4
endmodule

// File: rtl/dpr_port_ctrl.sv
module dpr_port_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sel_ni,
  input  logic rnw_i,
  input  logic oe_ni,
  input  logic busy_ni,
  output logic we_o,
  output logic re_o,
  output logic drive_o,
  output logic valid_o
);
  logic sel, rd;

  assign sel  = ~sel_ni;
  assign rd   = sel & rnw_i & ~oe_ni;
  assign we_o = sel & ~rnw_i & busy_ni;
  assign re_o = rd;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_o <= 1'b0;
      valid_o <= 1'b0;
    end else begin
      drive_o <= rd;
      valid_o <= rd & busy_ni;
    end
  end

  AST_BUSY_READ_FLAGGED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && rnw_i && !oe_ni && !busy_ni) |=> (drive_o && !valid_o)); // R9
  AST_VALID_NEEDS_DRIVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_o |-> drive_o); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_ni || oe_ni) |=> (!drive_o && !valid_o)); // R10
endmodule

// File: rtl/dpr_mem.sv
module dpr_mem
  import dpr_pkg::*;
#(
  parameter int unsigned AW = 10,
  parameter int unsigned DW = 8
) (
  input  logic                          clk_i,
  input  logic [NUM_PORTS-1:0]          we_i,
  input  logic [NUM_PORTS-1:0]          re_i,
  input  logic [NUM_PORTS-1:0][AW-1:0]  addr_i,
  input  logic [NUM_PORTS-1:0][DW-1:0]  wdata_i,
  output logic [NUM_PORTS-1:0][DW-1:0]  rdata_o
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i) begin
    for (int p = 0; p < NUM_PORTS; p++) begin
      if (we_i[p]) mem_q[addr_i[p]] <= wdata_i[p];
    end
  end

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_rd
    always_ff @(posedge clk_i) begin
      if (re_i[p]) rdata_o[p] <= mem_q[addr_i[p]];
    end
  end

  AST_NO_DOUBLE_WRITE: assert property (@(posedge clk_i)
    !(we_i[PORT_L] && we_i[PORT_R] && addr_i[PORT_L] == addr_i[PORT_R])); // R6
endmodule

// File: rtl/dpr_contention_ram.sv
module dpr_contention_ram
  import dpr_pkg::*;
#(
  parameter int unsigned AW       = 10,
  parameter int unsigned DW       = 8,
  parameter bit          TIE_LEFT = 1'b1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          l_sel_ni,
  input  logic          l_rnw_i,
  input  logic          l_oe_ni,
  input  logic [AW-1:0] l_addr_i,
  input  logic [DW-1:0] l_wdata_i,
  output logic [DW-1:0] l_rdata_o,
  output logic          l_drive_o,
  output logic          l_valid_o,
  output logic          l_busy_no,
  input  logic          r_sel_ni,
  input  logic          r_rnw_i,
  input  logic          r_oe_ni,
  input  logic [AW-1:0] r_addr_i,
  input  logic [DW-1:0] r_wdata_i,
  output logic [DW-1:0] r_rdata_o,
  output logic          r_drive_o,
  output logic          r_valid_o,
  output logic          r_busy_no
);
  logic [NUM_PORTS-1:0]         sel_n, rnw, oe_n, busy_n, we, re, drive, valid;
  logic [NUM_PORTS-1:0][AW-1:0] addr;
  logic [NUM_PORTS-1:0][DW-1:0] wdata, rdata;

  assign sel_n = {r_sel_ni, l_sel_ni};
  assign rnw   = {r_rnw_i, l_rnw_i};
  assign oe_n  = {r_oe_ni, l_oe_ni};
  assign addr  = {r_addr_i, l_addr_i};
  assign wdata = {r_wdata_i, l_wdata_i};

  dpr_arbiter #(.AW(AW), .TIE_LEFT(TIE_LEFT)) u_arb (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (~sel_n),
    .addr_l_i (l_addr_i),
    .addr_r_i (r_addr_i),
    .busy_no  (busy_n)
  );

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    dpr_port_ctrl u_ctrl (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .sel_ni  (sel_n[p]),
      .rnw_i   (rnw[p]),
      .oe_ni   (oe_n[p]),
      .busy_ni (busy_n[p]),
      .we_o    (we[p]),
      .re_o    (re[p]),
      .drive_o (drive[p]),
      .valid_o (valid[p])
    );
  end

  dpr_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk_i   (clk_i),
    .we_i    (we),
    .re_i    (re),
    .addr_i  (addr),
    .wdata_i (wdata),
    .rdata_o (rdata)
  );

  assign l_rdata_o = rdata[PORT_L];
  assign r_rdata_o = rdata[PORT_R];
  assign l_drive_o = drive[PORT_L];
  assign r_drive_o = drive[PORT_R];
  assign l_valid_o = valid[PORT_L];
  assign r_valid_o = valid[PORT_R];
  assign l_busy_no = busy_n[PORT_L];
  assign r_busy_no = busy_n[PORT_R];
endmodule

// File: tb/dpr_contention_ram_tb_top.sv
module dpr_contention_ram_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       l_sel_n = 1, l_rnw = 1, l_oe_n = 1, r_sel_n = 1, r_rnw = 1, r_oe_n = 1;
  logic [9:0] l_addr = '0, r_addr = '0;
  logic [7:0] l_wdata = '0, r_wdata = '0;
  logic [7:0] l_rdata, r_rdata;
  logic       l_drive, l_valid, l_busy_n, r_drive, r_valid, r_busy_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  typedef struct packed {
    bit       drive;
    bit       valid;
    bit       known;
    logic [7:0] data;
  } exp_t;

  exp_t  q_l[$], q_r[$];
  string t_l[$], t_r[$];
  logic [7:0] ref_mem [1024];
  bit         ref_known [1024];

  always #5 clk = ~clk;

  dpr_contention_ram dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .l_sel_ni(l_sel_n), .l_rnw_i(l_rnw), .l_oe_ni(l_oe_n), .l_addr_i(l_addr),
    .l_wdata_i(l_wdata), .l_rdata_o(l_rdata), .l_drive_o(l_drive),
    .l_valid_o(l_valid), .l_busy_no(l_busy_n),
    .r_sel_ni(r_sel_n), .r_rnw_i(r_rnw), .r_oe_ni(r_oe_n), .r_addr_i(r_addr),
    .r_wdata_i(r_wdata), .r_rdata_o(r_rdata), .r_drive_o(r_drive),
    .r_valid_o(r_valid), .r_busy_no(r_busy_n)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  function automatic exp_t predict(input bit sel_n, rnw, oe_n, busy, input logic [9:0] a);
    exp_t e;
    e.drive = !sel_n && rnw && !oe_n;
    e.valid = e.drive && busy;
    e.known = ref_known[a];
    e.data  = ref_mem[a];
    return e;
  endfunction

  task automatic step(input bit lc, lrw, loe, input logic [9:0] la, input logic [7:0] ld,
                      input bit rc, rrw, roe, input logic [9:0] ra, input logic [7:0] rd,
                      input bit ebl, ebr, input string tag);
    @(negedge clk);
    l_sel_n = lc; l_rnw = lrw; l_oe_n = loe; l_addr = la; l_wdata = ld;
    r_sel_n = rc; r_rnw = rrw; r_oe_n = roe; r_addr = ra; r_wdata = rd;
    #1;
    chk(l_busy_n == ebl, tag, "left busy_n", l_busy_n, ebl);
    chk(r_busy_n == ebr, tag, "right busy_n", r_busy_n, ebr);
    q_l.push_back(predict(lc, lrw, loe, ebl, la)); t_l.push_back(tag);
    q_r.push_back(predict(rc, rrw, roe, ebr, ra)); t_r.push_back(tag);
    if (!lc && !lrw && ebl) begin ref_mem[la] = ld; ref_known[la] = 1; end
    if (!rc && !rrw && ebr) begin ref_mem[ra] = rd; ref_known[ra] = 1; end
  endtask

  task automatic compare(input exp_t e, input string tag, input string side,
                         input logic drv, input logic vld, input logic [7:0] dat);
    chk(drv == e.drive, tag, {side, " drive"}, drv, e.drive);
    chk(vld == e.valid, tag, {side, " valid"}, vld, e.valid);
    if (e.valid && e.known) chk(dat == e.data, tag, {side, " rdata"}, dat, e.data);
  endtask

  // monitor: results of a request appear one edge later
  always @(negedge clk) begin
    if (q_l.size() > 0) compare(q_l.pop_front(), t_l.pop_front(), "left", l_drive, l_valid, l_rdata);
    if (q_r.size() > 0) compare(q_r.pop_front(), t_r.pop_front(), "right", r_drive, r_valid, r_rdata);
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 1024; i++) begin ref_known[i] = 0; ref_mem[i] = '0; end
    repeat (3) @(posedge clk);
    #2;
    chk(l_busy_n && r_busy_n, "R1", "busy in reset", {l_busy_n, r_busy_n}, 3);
    chk(!l_drive && !r_drive && !l_valid && !r_valid, "R1", "drive/valid in reset",
        {l_drive, r_drive, l_valid, r_valid}, 0);
    @(negedge clk); rst_n = 1'b1;
    step(1,1,1,10'h000,8'h00, 1,1,1,10'h000,8'h00, 1,1, "R1 idle after reset");
    step(0,0,1,10'h005,8'h11, 0,0,1,10'h006,8'h22, 1,1, "R2 R11 different-address writes");
    step(0,1,0,10'h006,8'h00, 0,1,0,10'h005,8'h00, 1,1, "R2 R8 cross reads");
    step(0,1,1,10'h005,8'h00, 1,1,1,10'h007,8'h00, 1,1, "R10 oe high");
    step(0,0,1,10'h010,8'h33, 1,1,1,10'h010,8'h00, 1,1, "R11 preload");
    step(0,1,0,10'h010,8'h00, 1,1,1,10'h010,8'h00, 1,1, "R3 left selected first");
    step(0,1,0,10'h010,8'h00, 0,0,1,10'h010,8'h44, 1,0, "R3 R6 sel order left wins");
    step(0,1,0,10'h010,8'h00, 0,0,1,10'h010,8'h44, 1,0, "R7 grant held");
    step(1,1,1,10'h010,8'h00, 0,0,1,10'h010,8'h44, 1,1, "R7 release deferred write");
    step(0,1,0,10'h010,8'h00, 1,1,1,10'h010,8'h00, 1,1, "R7 deferred data");
    step(1,1,1,10'h020,8'h00, 0,0,1,10'h020,8'h5a, 1,1, "R11 right preload");
    step(1,1,1,10'h020,8'h00, 0,1,0,10'h020,8'h00, 1,1, "R3 right selected first");
    step(0,0,1,10'h020,8'h55, 0,1,0,10'h020,8'h00, 0,1, "R3 R6 sel order right wins");
    step(1,1,1,10'h020,8'h00, 0,1,0,10'h020,8'h00, 1,1, "R6 blocked write left no effect");
    step(0,0,1,10'h030,8'h66, 0,0,1,10'h031,8'h67, 1,1, "R11 preload pair");
    step(0,1,0,10'h030,8'h00, 0,1,0,10'h031,8'h00, 1,1, "R4 both selected apart");
    step(0,1,0,10'h030,8'h00, 0,1,0,10'h030,8'h00, 1,0, "R4 R9 addr order left wins");
    step(0,1,0,10'h030,8'h00, 0,1,0,10'h031,8'h00, 1,1, "R7 right moves away");
    step(0,0,1,10'h040,8'h70, 0,1,0,10'h041,8'h00, 1,1, "R4 setup");
    step(0,0,1,10'h041,8'h71, 0,1,0,10'h041,8'h00, 0,1, "R4 R6 addr order right wins");
    step(0,0,1,10'h041,8'h71, 0,1,0,10'h042,8'h00, 1,1, "R7 deferred write after release");
    step(0,1,0,10'h041,8'h00, 0,1,0,10'h040,8'h00, 1,1, "R7 R8 readback");
    step(1,1,1,10'h050,8'h00, 1,1,1,10'h050,8'h00, 1,1, "R5 idle at shared address");
    step(0,0,1,10'h050,8'h77, 0,0,1,10'h050,8'h88, 1,0, "R5 tie sel order default left");
    step(1,1,1,10'h050,8'h00, 0,1,0,10'h050,8'h00, 1,1, "R5 tie result");
    step(0,1,0,10'h060,8'h00, 0,1,0,10'h061,8'h00, 1,1, "R5 apart");
    step(0,1,0,10'h062,8'h00, 0,1,0,10'h062,8'h00, 1,0, "R5 R9 tie addr order default left");
    step(1,1,1,10'h000,8'h00, 1,1,1,10'h000,8'h00, 1,1, "R10 idle");
    @(negedge clk);
    @(negedge clk);
    done = 1;
    summary();
    $finish;
  end
endmodule